// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase

This block produces the common time reference that a group of PWM channels compares against. An input tick source, either every cycle of the system clock or a slower reference enable, feeds a phase accumulator that divides it by a fixed-point ratio with eight fraction bits. Each divider tick advances a counter whose range is a run-time power of two. When the counter rolls over, the block raises a one-cycle wrap pulse.

Software drives a small configuration port. It sets the divider ratio, the resolution, the source select, a pause control and a clear control. A new divider or resolution is first held in a staging copy and takes effect only after an update strobe. The staged values are loaded at the next rollover, or at once while the counter is held clear. Whenever new settings are loaded, the accumulator phase restarts from zero.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset, `cnt_o` is 0 and `wrap_o` is 0.
- R2: The divider ratio is unsigned with 8 fraction bits, so 256 means 1.0. With the fast source, tick rate = 256/div per clock. Example: div=384 at resolution 2 gives a wrap period of 6 clocks.
- R3: On each tick the counter steps from 0 up to 2^res−1 and then returns to 0. Example: div=256, res=3 gives a wrap period of 8 clocks.
- R4: `wrap_o` is high for exactly one clock per rollover, in the same cycle that `cnt_o` first shows 0.
- R5: While `clr_i` is high, `cnt_o` is 0 and `wrap_o` stays low.
- R6: While `pause_i` is high, `cnt_o` holds its value. Counting resumes when `pause_i` falls.
- R7: Changes on `div_i` and `res_i` have no effect without a pulse on `upd_i`. After the pulse, the new values apply from the next rollover, or immediately while `clr_i` is high.
- R8: A divider below 256 acts as 256, giving one tick per source event. The largest divider, 0x3FFFF, gives tick intervals of 1023 or 1024 clocks.
- R9: A resolution above MAX_RES acts as MAX_RES.
- R10: With `sel_fast_i`=1, every clock is a source event. With 0, only clocks with `ref_en_i` high are source events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en_i | input | 1 | Slow reference enable, one clock wide per event |
| sel_fast_i | input | 1 | 1 selects every clock as the source, 0 selects ref_en_i |
| pause_i | input | 1 | Freeze counter and divider |
| clr_i | input | 1 | Hold counter at zero |
| upd_i | input | 1 | Strobe that stages div_i and res_i for loading |
| div_i | input | 18 | Divider ratio with 8 fraction bits |
| res_i | input | 5 | Counter resolution in bits |
| cnt_o | output | MAX_RES | Counter value |
| wrap_o | output | 1 | One-clock rollover pulse |

## Verification
The in-RTL assertions check the following on every cycle:
- the counter stays within its current range;
- a wrap coincides with a zero count;
- clear and pause take hold on the following cycle;
- the accumulator residue stays below the active divider;
- the active settings never change without a pending update.

Only the bench scenarios can show the rate-dependent behaviour. They measure wrap periods under integer and fractional dividers, the divider extremes, the clamped resolution and the slow source. They also check that a staged change waits for a rollover boundary before it alters the period.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  localparam int DIV_W  = 18;
  localparam int FRAC_W = 8;
  localparam int RES_W  = 5;
  localparam logic [DIV_W-1:0] DIV_UNITY = DIV_W'(1 << FRAC_W);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [RES_W-1:0] res;
  } tb_cfg_t;
endpackage

// File: rtl/pwm_tb_fracdiv.sv
module pwm_tb_fracdiv
  import pwm_tb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int SUM_W = DIV_W + 1;

  logic [DIV_W-1:0] acc_q;
  logic [DIV_W-1:0] div_eff;
  logic [SUM_W-1:0] sum;
  logic             reach;
  logic [SUM_W-1:0] rem;

  // ratios below 1.0 are raised to 1.0
  assign div_eff = (div_i < DIV_UNITY) ? DIV_UNITY : div_i;
  assign sum     = {1'b0, acc_q} + {1'b0, DIV_UNITY};
  assign reach   = sum >= {1'b0, div_eff};
  assign rem     = reach ? (sum - {1'b0, div_eff}) : sum;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (en_i) begin
      tick_o <= reach;
      acc_q  <= load_i ? '0 : rem[DIV_W-1:0];
    end else begin
      tick_o <= 1'b0;
      if (load_i) acc_q <= '0;
    end
  end

  AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    acc_q < div_eff); // R2
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int MAX_RES = 20,
  localparam int CNT_W = MAX_RES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             pause_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] res_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             roll_o
);
  logic [RES_W-1:0] res_eff;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] top;

  assign res_eff = (res_i > RES_W'(MAX_RES)) ? RES_W'(MAX_RES) : res_i;
  assign span    = {{CNT_W{1'b0}}, 1'b1} << res_eff;
  assign top     = span[CNT_W-1:0] - 1'b1;
  assign roll_o  = tick_i && !pause_i && !clr_i && (cnt_o >= top);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o  <= '0;
      wrap_o <= 1'b0;
    end else if (roll_o) begin
      cnt_o  <= '0;
      wrap_o <= 1'b1;
    end else begin
      wrap_o <= 1'b0;
      if (tick_i && !pause_i) cnt_o <= cnt_o + 1'b1;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= top); // R3
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (cnt_o == '0)); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0) && !wrap_o); // R5
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pause_i && !clr_i) |=> (cnt_o == $past(cnt_o))); // R6
endmodule

// File: rtl/pwm_tb_shadow.sv
module pwm_tb_shadow
  import pwm_tb_pkg::*;
#(
  parameter int RES_RST = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    upd_i,
  input  tb_cfg_t cfg_i,
  input  logic    apply_i,
  output tb_cfg_t act_o,
  output logic    load_o
);
  tb_cfg_t stg_q;
  logic    pend_q;

  assign load_o = pend_q && apply_i && !upd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q     <= '0;
      pend_q    <= 1'b0;
      act_o.div <= DIV_UNITY;
      act_o.res <= RES_W'(RES_RST);
    end else if (upd_i) begin
      stg_q  <= cfg_i;
      pend_q <= 1'b1;
    end else if (load_o) begin
      act_o  <= stg_q;
      pend_q <= 1'b0;
    end
  end

  AST_NO_LOAD_WITHOUT_PEND: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> $stable(act_o)); // R7
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int MAX_RES = 20,
  parameter int RES_RST = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_en_i,
  input  logic               sel_fast_i,
  input  logic               pause_i,
  input  logic               clr_i,
  input  logic               upd_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [RES_W-1:0]   res_i,
  output logic [MAX_RES-1:0] cnt_o,
  output logic               wrap_o
);
  tb_cfg_t cfg_in, cfg_act;
  logic    src_en, div_en, tick, roll, load;

  assign cfg_in.div = div_i;
  assign cfg_in.res = res_i;
  assign src_en = sel_fast_i ? 1'b1 : ref_en_i;
  assign div_en = src_en && !pause_i;

  pwm_tb_shadow #(.RES_RST(RES_RST)) u_shadow (
    .clk(clk), .rst(rst), .upd_i(upd_i), .cfg_i(cfg_in),
    .apply_i(roll || clr_i), .act_o(cfg_act), .load_o(load)
  );

  pwm_tb_fracdiv u_div (
    .clk(clk), .rst(rst), .en_i(div_en), .clr_i(clr_i),
    .load_i(load), .div_i(cfg_act.div), .tick_o(tick)
  );

  pwm_tb_counter #(.MAX_RES(MAX_RES)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .pause_i(pause_i), .clr_i(clr_i),
    .res_i(cfg_act.res), .cnt_o(cnt_o), .wrap_o(wrap_o), .roll_o(roll)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt_o == '0) && !wrap_o); // R1
endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  localparam int MR = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_en = 1'b0, sel_fast = 1'b1, pause = 1'b0, clr = 1'b0, upd = 1'b0;
  logic [17:0] div = 18'd256;
  logic [4:0]  res = 5'd3;
  logic [MR-1:0] cnt;
  logic wrap;
  int cyc = 0, total = 0, fails = 0;
  bit ref_on = 1'b0;
  int ref_ph = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_timebase #(.MAX_RES(MR)) u_pwm_timebase (
    .clk(clk), .rst(rst), .ref_en_i(ref_en), .sel_fast_i(sel_fast),
    .pause_i(pause), .clr_i(clr), .upd_i(upd), .div_i(div), .res_i(res),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  // reference enable: one clock high every 5 clocks when switched on
  always @(negedge clk) begin
    ref_ph <= (ref_ph == 4) ? 0 : ref_ph + 1;
    ref_en <= ref_on && (ref_ph == 4);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_wrap(input string req);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!wrap && guard < 5000);
    if (guard >= 5000) chk(1'b0, req, 0, 1);
  endtask

  task automatic period(input string req, output int p);
    int t0;
    wait_wrap(req);
    t0 = cyc;
    wait_wrap(req);
    p = cyc - t0;
  endtask

  task automatic setup(input int d, input int r, input bit f);
    @(negedge clk);
    clr = 1'b1; div = 18'(d); res = 5'(r); sel_fast = f; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cnt == 0, "R1 cnt", int'(cnt), 0);
    chk(wrap == 1'b0, "R1 wrap", int'(wrap), 0);
  endtask

  task automatic t_basic;
    int p;
    setup(256, 3, 1'b1);
    period("R3 period", p);
    chk(p == 8, "R3 period", p, 8);
    chk(cnt == 0, "R4 cnt at wrap", int'(cnt), 0);
    @(negedge clk);
    chk(wrap == 1'b0, "R4 width", int'(wrap), 0);
    period("R3 period", p);
    chk(p == 8, "R3 period again", p, 8);
  endtask

  task automatic t_frac;
    int p;
    setup(384, 2, 1'b1);
    period("R2 frac", p);
    chk(p == 6, "R2 frac period", p, 6);
    period("R2 frac", p);
    chk(p == 6, "R2 frac period again", p, 6);
  endtask

  task automatic t_divs;
    int p;
    setup(100, 2, 1'b1);
    period("R8 low", p);
    chk(p == 4, "R8 low divider", p, 4);
    setup(18'h3FFFF, 0, 1'b1);
    period("R8 max", p);
    chk(p == 1023 || p == 1024, "R8 max divider", p, 1024);
  endtask

  task automatic t_clamp;
    int p;
    setup(256, 31, 1'b1);
    period("R9 clamp", p);
    chk(p == 64, "R9 clamp 31", p, 64);
    setup(256, 7, 1'b1);
    period("R9 clamp", p);
    chk(p == 64, "R9 clamp 7", p, 64);
  endtask

  task automatic t_source;
    int p;
    ref_on = 1'b1;
    setup(256, 2, 1'b0);
    period("R10 slow", p);
    chk(p == 20, "R10 slow source", p, 20);
    setup(256, 2, 1'b1);
    period("R10 fast", p);
    chk(p == 4, "R10 fast ignores ref", p, 4);
    ref_on = 1'b0;
  endtask

  task automatic t_pause;
    logic [MR-1:0] snap;
    bit saw_wrap = 1'b0;
    setup(256, 5, 1'b1);
    repeat (10) @(negedge clk);
    pause = 1'b1;
    repeat (2) @(negedge clk);
    snap = cnt;
    repeat (15) begin
      @(negedge clk);
      if (wrap) saw_wrap = 1'b1;
    end
    chk(cnt == snap, "R6 frozen", int'(cnt), int'(snap));
    chk(!saw_wrap, "R6 no wrap", int'(saw_wrap), 0);
    pause = 1'b0;
    repeat (4) @(negedge clk);
    chk(cnt != snap, "R6 resumes", int'(cnt), int'(snap) + 1);
  endtask

  task automatic t_clr;
    bit bad = 1'b0;
    setup(256, 2, 1'b1);
    repeat (7) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    repeat (10) begin
      @(negedge clk);
      if (cnt != 0 || wrap) bad = 1'b1;
    end
    chk(!bad, "R5 held clear", int'(bad), 0);
    clr = 1'b0;
  endtask

  task automatic t_shadow;
    int p, t0;
    setup(256, 3, 1'b1);
    res = 5'd2;
    div = 18'd512;
    period("R7 ignored", p);
    chk(p == 8, "R7 no strobe no effect", p, 8);
    t0 = cyc;
    repeat (3) @(negedge clk);
    div = 18'd256;
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    wait_wrap("R7 boundary");
    p = cyc - t0;
    chk(p == 8, "R7 old period kept", p, 8);
    t0 = cyc;
    wait_wrap("R7 new");
    p = cyc - t0;
    chk(p == 4, "R7 new period", p, 4);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_frac();
    t_divs();
    t_clamp();
    t_source();
    t_pause();
    t_clr();
    t_shadow();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule